// File: doc/BRIEF.md
# DDR Input Capture with Half-Rate Demultiplexer

This block takes a SIZE-bit bus arriving from the pads and hands it to the core logic in one of four capture styles, chosen by the `cap_mode` input. The bus can pass straight through, or be registered once on the full-rate clock. It can also be sampled on both edges of the full-rate clock and presented as a two-word bus. The last style adds a second stage that gathers two such pairs into one four-word bus on a half-rate clock. In every style the data rate times the bus width stays the same.

The half-rate clock must run at exactly half the full-rate frequency, with its rising edges on rising edges of the full-rate clock. A clock enable stalls every capture register. A stalled cycle adds no word to the stream. A synchronous force and an asynchronous force are each built as a clear, a set or absent, chosen by parameter. One force signal of each kind serves every capture register. The active-low reset is asynchronous, and its release must be synchronous to `clk_fr`. The capture registers run in every mode and `cap_mode` only selects the output, so the mode may change on any cycle.

Top module: `ddr_in_capture`

## Requirements
- R1: With `cap_mode`=0 (bypass), `core_dout[SIZE-1:0]` equals `pad_in` with no clock in between, and all higher bits are zero.
- R2: With `cap_mode`=1 (single-edge register), `core_dout[SIZE-1:0]` holds the `pad_in` value sampled at the last enabled rising edge of `clk_fr`, and all higher bits are zero.
- R3: With `cap_mode`=2 (full-rate DDR), after an enabled rising edge of `clk_fr`, `core_dout[2*SIZE-1:0]` shows the previous complete enabled cycle. Its rising-edge sample is in bits [SIZE-1:0] and its falling-edge sample is in bits [2*SIZE-1:SIZE]. Bits above 2*SIZE are zero.
- R4: With `cap_mode`=3 (half-rate), `core_dout` carries four words. In order of arrival they are rise0, fall0, rise1, fall1, placed from bits [SIZE-1:0] upward, so the earliest word is right-most. The first word captured after reset or a force sits in bits [SIZE-1:0].
- R5: The four-word output changes only on rising edges of `clk_hr`, and only to a group whose four words have all been assembled.
- R6: While `cke` is low, every capture register holds its value. The outputs of modes 1 to 3 do not advance, and the stalled cycle adds no word to any pair or group.
- R7: With the default clear variant, `sync_force` high zeroes every capture register at its next clock edge, regardless of `cke`. Pairing and grouping restart, so the next enabled rising sample becomes word 0.
- R8: With the default set variant, `async_force` high drives every capture register to all ones at once, without a clock edge. Pairing and grouping restart after it is released.
- R9: While `rst_n` is low, `core_dout` is zero in modes 1 to 3.
- R10: Changing `cap_mode` does not disturb capture. Each mode shows its current result as soon as it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Full-rate clock; data is sampled on both of its edges |
| clk_hr | input | 1 | Half-rate clock, rising edges aligned to rising edges of clk_fr |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cap_mode | input | 2 | 0 bypass, 1 single register, 2 full-rate DDR, 3 half-rate |
| cke | input | 1 | Clock enable for all capture registers |
| async_force | input | 1 | Asynchronous force, active high (set by default) |
| sync_force | input | 1 | Synchronous force, active high (clear by default) |
| pad_in | input | SIZE | Data bus from the pads |
| core_dout | output | 4*SIZE | Core-side bus; unused upper bits are zero |

## Verification
A wrong pairing decision shows up at the ports within one enabled full-rate cycle in DDR mode, as two words swapped or taken from different cycles. A wrong half-rate group phase shows up on the next `clk_hr` rising edge in mode 3, as a word appearing in the wrong slot. A clock enable that leaks through, or a force that fails to restart grouping, leaves every later word misplaced, so each cycle after it fails. The bench predicts each mode's output with a queue-based model and compares it once per full-rate cycle. This includes runs with stalls, forces and a mode change on every cycle.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
  typedef enum logic [1:0] {
    CAP_BYPASS = 2'd0,
    CAP_SINGLE = 2'd1,
    CAP_DDR    = 2'd2,
    CAP_QUAD   = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_ZERO = 2'd1,
    FORCE_ONE  = 2'd2
  } force_kind_e;
endpackage

// File: rtl/ddrcap_edge_pair.sv
// Dual-edge sampling of the pad bus on the full-rate clock.
module ddrcap_edge_pair #(
  parameter int SIZE = 8
) (
  input  logic            clk_fr,
  input  logic            rst_n,
  input  logic            async_hit,
  input  logic            async_fill,
  input  logic            sync_hit,
  input  logic            sync_fill,
  input  logic            cke,
  input  logic [SIZE-1:0] pad_in,
  output logic [SIZE-1:0] rise_q,
  output logic [SIZE-1:0] fall_q
);
  logic [SIZE-1:0] rise_d, fall_d;

  always_comb begin
    rise_d = rise_q;
    fall_d = fall_q;
    if (sync_hit) begin
      rise_d = {SIZE{sync_fill}};
      fall_d = {SIZE{sync_fill}};
    end else if (cke) begin
      rise_d = pad_in;
      fall_d = pad_in;
    end
  end

  always_ff @(posedge clk_fr or negedge rst_n or posedge async_hit) begin
    if (!rst_n)         rise_q <= '0;
    else if (async_hit) rise_q <= {SIZE{async_fill}};
    else                rise_q <= rise_d;
  end

  always_ff @(negedge clk_fr or negedge rst_n or posedge async_hit) begin
    if (!rst_n)         fall_q <= '0;
    else if (async_hit) fall_q <= {SIZE{async_fill}};
    else                fall_q <= fall_d;
  end
endmodule

// File: rtl/ddrcap_pair_align.sv
// Retimes a completed rise/fall pair onto the rising edge; pairs start after reset.
module ddrcap_pair_align #(
  parameter int SIZE = 8
) (
  input  logic              clk_fr,
  input  logic              rst_n,
  input  logic              async_hit,
  input  logic              async_fill,
  input  logic              sync_hit,
  input  logic              sync_fill,
  input  logic              cke,
  input  logic [SIZE-1:0]   rise_q,
  input  logic [SIZE-1:0]   fall_q,
  output logic [2*SIZE-1:0] pair_q,
  output logic              pair_load
);
  localparam int PW = 2 * SIZE;

  logic          pend_q, pend_d;
  logic [PW-1:0] pair_d;

  assign pair_load = cke & pend_q & ~sync_hit;

  always_comb begin
    pend_d = pend_q;
    pair_d = pair_q;
    if (sync_hit) begin
      pend_d = 1'b0;
      pair_d = {PW{sync_fill}};
    end else if (cke) begin
      pend_d = 1'b1;
      if (pend_q) pair_d = {fall_q, rise_q};
    end
  end

  always_ff @(posedge clk_fr or negedge rst_n or posedge async_hit) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pair_q <= '0;
    end else if (async_hit) begin
      pend_q <= 1'b0;
      pair_q <= {PW{async_fill}};
    end else begin
      pend_q <= pend_d;
      pair_q <= pair_d;
    end
  end
endmodule

// File: rtl/ddrcap_halfrate.sv
// Gathers two pairs into a four-word group and presents it on the half-rate clock.
module ddrcap_halfrate #(
  parameter int SIZE = 8
) (
  input  logic              clk_fr,
  input  logic              clk_hr,
  input  logic              rst_n,
  input  logic              async_hit,
  input  logic              async_fill,
  input  logic              sync_hit,
  input  logic              sync_fill,
  input  logic              pair_load,
  input  logic [2*SIZE-1:0] new_pair,
  input  logic [2*SIZE-1:0] old_pair,
  output logic [4*SIZE-1:0] quad_hr
);
  localparam int QW = 4 * SIZE;

  logic          ph_q, ph_d;
  logic [QW-1:0] quad_q, quad_d, hr_d;

  always_comb begin
    ph_d   = ph_q;
    quad_d = quad_q;
    if (sync_hit) begin
      ph_d   = 1'b0;
      quad_d = {QW{sync_fill}};
    end else if (pair_load) begin
      ph_d = ~ph_q;
      if (ph_q) quad_d = {new_pair, old_pair};
    end
  end

  always_comb begin
    hr_d = sync_hit ? {QW{sync_fill}} : quad_q;
  end

  always_ff @(posedge clk_fr or negedge rst_n or posedge async_hit) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      quad_q <= '0;
    end else if (async_hit) begin
      ph_q   <= 1'b0;
      quad_q <= {QW{async_fill}};
    end else begin
      ph_q   <= ph_d;
      quad_q <= quad_d;
    end
  end

  always_ff @(posedge clk_hr or negedge rst_n or posedge async_hit) begin
    if (!rst_n)         quad_hr <= '0;
    else if (async_hit) quad_hr <= {QW{async_fill}};
    else                quad_hr <= hr_d;
  end
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddrcap_pkg::*;
#(
  parameter int          SIZE       = 8,
  parameter force_kind_e ASYNC_KIND = FORCE_ONE,
  parameter force_kind_e SYNC_KIND  = FORCE_ZERO
) (
  input  logic              clk_fr,
  input  logic              clk_hr,
  input  logic              rst_n,
  input  logic [1:0]        cap_mode,
  input  logic              cke,
  input  logic              async_force,
  input  logic              sync_force,
  input  logic [SIZE-1:0]   pad_in,
  output logic [4*SIZE-1:0] core_dout
);
  localparam int PW = 2 * SIZE;
  localparam int QW = 4 * SIZE;

  logic            async_hit, sync_hit;
  logic            async_fill, sync_fill;
  logic [SIZE-1:0] rise_q, fall_q;
  logic [PW-1:0]   pair_q;
  logic            pair_load;
  logic [QW-1:0]   quad_hr;
  cap_mode_e       mode_sel;

  generate
    if (ASYNC_KIND == FORCE_NONE) begin : g_no_async
      assign async_hit = 1'b0;
    end else begin : g_async
      assign async_hit = async_force;
    end
    if (SYNC_KIND == FORCE_NONE) begin : g_no_sync
      assign sync_hit = 1'b0;
    end else begin : g_sync
      assign sync_hit = sync_force;
    end
  endgenerate

  assign async_fill = (ASYNC_KIND == FORCE_ONE);
  assign sync_fill  = (SYNC_KIND == FORCE_ONE);

  ddrcap_edge_pair #(.SIZE(SIZE)) u_edge (
    .clk_fr(clk_fr), .rst_n(rst_n),
    .async_hit(async_hit), .async_fill(async_fill),
    .sync_hit(sync_hit), .sync_fill(sync_fill),
    .cke(cke), .pad_in(pad_in),
    .rise_q(rise_q), .fall_q(fall_q)
  );

  ddrcap_pair_align #(.SIZE(SIZE)) u_align (
    .clk_fr(clk_fr), .rst_n(rst_n),
    .async_hit(async_hit), .async_fill(async_fill),
    .sync_hit(sync_hit), .sync_fill(sync_fill),
    .cke(cke), .rise_q(rise_q), .fall_q(fall_q),
    .pair_q(pair_q), .pair_load(pair_load)
  );

  ddrcap_halfrate #(.SIZE(SIZE)) u_half (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .rst_n(rst_n),
    .async_hit(async_hit), .async_fill(async_fill),
    .sync_hit(sync_hit), .sync_fill(sync_fill),
    .pair_load(pair_load), .new_pair({fall_q, rise_q}), .old_pair(pair_q),
    .quad_hr(quad_hr)
  );

  assign mode_sel = cap_mode_e'(cap_mode);

  always_comb begin
    core_dout = '0;
    unique case (mode_sel)
      CAP_BYPASS: core_dout[SIZE-1:0] = pad_in;
      CAP_SINGLE: core_dout[SIZE-1:0] = rise_q;
      CAP_DDR:    core_dout[PW-1:0]   = pair_q;
      CAP_QUAD:   core_dout           = quad_hr;
      default:    core_dout           = '0;
    endcase
  end
endmodule

// File: rtl/ddr_in_capture_checker.sv
module ddr_in_capture_checker
  import ddrcap_pkg::*;
#(
  parameter int          SIZE      = 8,
  parameter force_kind_e SYNC_KIND = FORCE_ZERO
) (
  input logic              clk_fr,
  input logic              rst_n,
  input logic [1:0]        cap_mode,
  input logic              sync_force,
  input logic [SIZE-1:0]   pad_in,
  input logic [4*SIZE-1:0] core_dout
);
  localparam int QW = 4 * SIZE;

  // R1: bypass passes the pad bus straight through, upper bits zero
  p_bypass_passthru_r1: assert property (@(posedge clk_fr) disable iff (!rst_n)
    (cap_mode == 2'd0) |-> (core_dout == {{(QW-SIZE){1'b0}}, pad_in}));

  // R2: single-register mode drives only the low word
  p_single_upper_zero_r2: assert property (@(posedge clk_fr) disable iff (!rst_n)
    (cap_mode == 2'd1) |-> (core_dout[QW-1:SIZE] == '0));

  // R3: full-rate DDR mode drives only the low two words
  p_ddr_upper_zero_r3: assert property (@(posedge clk_fr) disable iff (!rst_n)
    (cap_mode == 2'd2) |-> (core_dout[QW-1:2*SIZE] == '0));

  // R7: a synchronous clear empties the single and DDR outputs by the next edge
  p_sync_clears_r7: assert property (@(posedge clk_fr) disable iff (!rst_n)
    (sync_force && (SYNC_KIND == FORCE_ZERO)) |=>
      ((cap_mode != 2'd1 && cap_mode != 2'd2) || core_dout == '0));

  // R9: while reset is held, every registered mode reads zero
  p_reset_zero_r9: assert property (@(posedge clk_fr)
    (!rst_n && cap_mode != 2'd0) |-> (core_dout == '0));
endmodule

bind ddr_in_capture ddr_in_capture_checker #(.SIZE(SIZE), .SYNC_KIND(SYNC_KIND)) u_checker (
  .clk_fr(clk_fr), .rst_n(rst_n), .cap_mode(cap_mode),
  .sync_force(sync_force), .pad_in(pad_in), .core_dout(core_dout)
);

// File: tb/ddr_in_capture_bench.sv
module ddr_in_capture_bench;
  localparam int SIZE = 8;
  localparam int PW   = 2 * SIZE;
  localparam int QW   = 4 * SIZE;

  logic            clk_fr = 1'b0;
  logic            clk_hr = 1'b0;
  logic            rst_n  = 1'b1;
  logic [1:0]      mode   = 2'd1;
  logic            cke    = 1'b0;
  logic            afrc   = 1'b0;
  logic            sfrc   = 1'b0;
  logic [SIZE-1:0] pad    = 8'h5a;
  logic [QW-1:0]   dout;

  int nrise  = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ddr_in_capture #(.SIZE(SIZE)) u_ddr_in_capture (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .rst_n(rst_n), .cap_mode(mode),
    .cke(cke), .async_force(afrc), .sync_force(sfrc),
    .pad_in(pad), .core_dout(dout)
  );

  // 50 MHz full-rate clock; half-rate clock toggles on each full-rate rise
  initial begin
    forever begin
      #10;
      nrise  = nrise + 1;
      clk_fr = 1'b1;
      clk_hr = ~clk_hr;
      #10;
      clk_fr = 1'b0;
    end
  end

  // behavioural reference: queues of accepted words
  logic [SIZE-1:0] m_single = '0;
  logic [PW-1:0]   m_ddr    = '0;
  logic [QW-1:0]   m_quad   = '0;
  logic [QW-1:0]   m_hr     = '0;
  logic [SIZE-1:0] half[$];
  logic [PW-1:0]   grp[$];

  function automatic logic [SIZE-1:0] word(input int n);
    return SIZE'((n * 53 + 7) ^ (n >> 2));
  endfunction

  function automatic logic [QW-1:0] expect_out(input logic [1:0] md, input logic [SIZE-1:0] byp);
    case (md)
      2'd0:    return {{(QW-SIZE){1'b0}}, byp};
      2'd1:    return {{(QW-SIZE){1'b0}}, m_single};
      2'd2:    return {{(QW-PW){1'b0}}, m_ddr};
      default: return m_hr;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [QW-1:0] exp;
    exp = expect_out(mode, pad);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: mode=%0d actual=%h expected=%h", tag, mode, dout, exp);
    end
  endtask

  task automatic model_rise(input logic [SIZE-1:0] ra, input logic ce, input logic sy);
    logic [QW-1:0] quad_old;
    bit hr_edge;
    hr_edge  = (nrise % 2) == 1;
    quad_old = m_quad;
    if (sy) begin
      m_single = '0; m_ddr = '0; m_quad = '0;
      half.delete(); grp.delete();
      if (hr_edge) m_hr = '0;
    end else begin
      if (hr_edge) m_hr = quad_old;
      if (ce) begin
        if (half.size() == 2) begin
          m_ddr = {half[1], half[0]};
          grp.push_back(m_ddr);
          if (grp.size() == 2) begin
            m_quad = {grp[1], grp[0]};
            grp.delete();
          end
        end
        half.delete();
        half.push_back(ra);
        m_single = ra;
      end
    end
  endtask

  task automatic model_fall(input logic [SIZE-1:0] fa, input logic ce, input logic sy);
    if (!sy && ce && half.size() == 1) half.push_back(fa);
  endtask

  // one full-rate cycle, entered and left at a falling edge
  task automatic step(input logic [1:0] md, input logic [SIZE-1:0] ra, input logic [SIZE-1:0] fa,
                      input logic ce, input logic sy, input string tag);
    #5;
    mode = md; pad = ra; cke = ce; sfrc = sy;
    @(posedge clk_fr);
    model_rise(ra, ce, sy);
    #2;
    check(tag);
    #3;
    pad = fa;
    @(negedge clk_fr);
    model_fall(fa, ce, sy);
  endtask

  task automatic async_pulse(input logic [1:0] md, input logic [SIZE-1:0] ra, input string tag);
    #3;
    mode = md; pad = ra; cke = 1'b1; sfrc = 1'b0; afrc = 1'b1;
    m_single = '1; m_ddr = '1; m_quad = '1; m_hr = '1;
    half.delete(); grp.delete();
    #3;
    check(tag);
    #1;
    afrc = 1'b0;
    @(posedge clk_fr);
    model_rise(ra, 1'b1, 1'b0);
    #2;
    check(tag);
    #3;
    pad = ra + 8'd1;
    @(negedge clk_fr);
    model_fall(ra + 8'd1, 1'b1, 1'b0);
  endtask

  initial begin
    int n;
    n = 0;
    #1 rst_n = 1'b0;
    @(negedge clk_fr);
    @(negedge clk_fr);
    #2; check("R9 reset single");
    mode = 2'd3; #1; check("R9 reset half-rate");
    mode = 2'd0; #1; check("R1 bypass during reset");
    @(negedge clk_fr);
    #1 rst_n = 1'b1;
    @(negedge clk_fr);

    // R2: single-edge register
    for (int i = 0; i < 6; i++) begin step(2'd1, word(n), word(n + 500), 1'b1, 1'b0, "R2 single"); n++; end
    // R1: bypass
    for (int i = 0; i < 3; i++) begin step(2'd0, word(n), word(n + 500), 1'b1, 1'b0, "R1 bypass"); n++; end
    // R3: full-rate DDR pairs
    for (int i = 0; i < 6; i++) begin step(2'd2, word(n), word(n + 500), 1'b1, 1'b0, "R3 ddr"); n++; end
    // R4: half-rate groups of four
    for (int i = 0; i < 12; i++) begin step(2'd3, word(n), word(n + 500), 1'b1, 1'b0, "R4 half-rate"); n++; end
    // R5 and R6: stalls inside groups
    for (int i = 0; i < 14; i++) begin
      step(2'd3, word(n), word(n + 500), (i % 3) != 1, 1'b0, "R5 group only when complete"); n++;
    end
    for (int i = 0; i < 8; i++) begin
      step(2'd2, word(n), word(n + 500), (i % 4) < 2, 1'b0, "R6 stall holds"); n++;
    end
    for (int i = 0; i < 4; i++) begin step(2'd1, word(n), word(n + 500), 1'b0, 1'b0, "R6 single held"); n++; end
    // R7: synchronous clear overriding a low enable, then regrouping
    step(2'd2, word(n), word(n + 500), 1'b0, 1'b1, "R7 sync clear"); n++;
    step(2'd2, word(n), word(n + 500), 1'b1, 1'b1, "R7 sync clear"); n++;
    for (int i = 0; i < 4; i++) begin step(2'd2, word(n), word(n + 500), 1'b1, 1'b0, "R7 regroup"); n++; end
    for (int i = 0; i < 10; i++) begin step(2'd3, word(n), word(n + 500), 1'b1, 1'b0, "R4 first word low"); n++; end
    // R8: asynchronous set
    async_pulse(2'd3, word(n), "R8 async set"); n++;
    for (int i = 0; i < 8; i++) begin step(2'd3, word(n), word(n + 500), 1'b1, 1'b0, "R8 regroup"); n++; end
    async_pulse(2'd1, word(n), "R8 async set single"); n++;
    for (int i = 0; i < 3; i++) begin step(2'd2, word(n), word(n + 500), 1'b1, 1'b0, "R8 ddr after set"); n++; end
    // R10: mode changes every cycle
    for (int i = 0; i < 20; i++) begin
      step(2'(i % 4), word(n), word(n + 500), (i % 5) != 3, 1'b0, "R10 mode rotation"); n++;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule